// File: doc/BRIEF.md
# Receiver error flag generator

This block drives the error indication of a digital audio interface receiver. Every cycle it sees six event lines from the frame decoder: PLL unlock, parity error, validity flag, non-PCM detect, sample rate outside its limits, and sample rate change. An internal cause mask selects which of these events set the flag. Any enabled event raises the flag in the same cycle.

Three of the causes are held after they go away: unlock, rate out of limits and rate change. Once one of them has been seen, the flag stays high until a programmed number of block-start preambles has passed with no enabled error. The preamble count is taken from a one-cycle strobe sent by the frame decoder. The other three causes (parity, validity, non-PCM) show on the flag only while they are present.

The block also drives the shared status pin. Depending on a gating mode and on the selected main output source, the pin carries the error flag or a forced error level. A select bit can route an external interrupt line to the pin instead, and a separate bit turns the pin driver off.

Top module: `rx_fault_flag`

## Requirements
- R1: The cause mask bits are: bit0 unlock, bit1 parity, bit2 validity, bit3 non-PCM, bit4 rate out of limits, bit5 rate change. When an event line is high and its mask bit is set, `err_flag` is high in that same cycle.
- R2: An event whose mask bit is clear has no effect on `err_flag`.
- R3: After reset the mask is 6'b000001, so only unlock is enabled. `err_flag` is high out of reset and stays high until the first full release count completes.
- R4: After an enabled unlock, rate-limit or rate-change event, `err_flag` stays high until `rel_sel` block-start strobes have passed with no enabled error. The encoding is 2'b00=48, 2'b01=12, 2'b10=6, 2'b11=3. The flag is low in the cycle after the final strobe.
- R5: An enabled error seen while the flag is being held restarts the preamble count from zero.
- R6: Enabled parity, validity and non-PCM events raise `err_flag` only while the event is present. They are not held once the event goes away.
- R7: Preambles are counted only on cycles where `blk_start` is high. With no strobes the flag stays held however long it waits.
- R8: With `gate_mode`=0 the pin shows `err_flag`. With `gate_mode`=1 the pin shows `err_flag` only when `main_src` is 3'd0 (automatic) or 3'd1 (receiver). For any other source the pin is driven high.
- R9: With `pin_sel`=1 the pin carries `irq_in` in place of the error status.
- R10: With `pin_hiz`=1 the pin driver is off (`pin_oe`=0). With `pin_hiz`=0, `pin_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_unlock | input | 1 | PLL unlock event |
| ev_parity | input | 1 | Parity error event |
| ev_validity | input | 1 | Validity flag event |
| ev_nonpcm | input | 1 | Non-PCM detect event |
| ev_rate_lim | input | 1 | Sample rate outside limits |
| ev_rate_chg | input | 1 | Sample rate change |
| blk_start | input | 1 | One-cycle block-start preamble strobe |
| mask_wdata | input | 6 | New cause mask value |
| mask_we | input | 1 | Load `mask_wdata` into the cause mask |
| rel_sel | input | 2 | Release wait select |
| gate_mode | input | 1 | Pin gating by main source |
| main_src | input | 3 | Selected main output source |
| pin_sel | input | 1 | 0 = error status on pin, 1 = interrupt |
| irq_in | input | 1 | Interrupt line for the shared pin |
| pin_hiz | input | 1 | Turn the pin driver off |
| err_flag | output | 1 | Receiver error flag |
| pin_out | output | 1 | Shared pin value |
| pin_oe | output | 1 | Shared pin output enable |

## Verification
`err_flag`, `pin_out` and `pin_oe` respond to event, mux and gating inputs within the same cycle. The bench drives these inputs on the falling edge and samples the outputs before the next rising edge. A mask write takes effect one rising edge after `mask_we`. The release lands one edge after the final strobe. Each release test checks the flag after N-1 strobes, where it must still be high, and again after the Nth, where it must be low. This proves the count is exact.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int NCAUSE = 6;

    localparam int C_UNLOCK   = 0;
    localparam int C_PARITY   = 1;
    localparam int C_VALIDITY = 2;
    localparam int C_NONPCM   = 3;
    localparam int C_RATE_LIM = 4;
    localparam int C_RATE_CHG = 5;

    typedef logic [NCAUSE-1:0] cause_vec_t;

    // causes whose effect outlasts the event and needs the preamble count
    localparam cause_vec_t HELD_CAUSES = cause_vec_t'(
        (1 << C_UNLOCK) | (1 << C_RATE_LIM) | (1 << C_RATE_CHG));

    localparam cause_vec_t MASK_AT_RESET = cause_vec_t'(1 << C_UNLOCK);

    localparam int SRC_W    = 3;
    localparam int SRC_AUTO = 0;
    localparam int SRC_RX   = 1;
endpackage

// File: rtl/rxf_cause_gate.sv
module rxf_cause_gate
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cause_vec_t events,
    input  cause_vec_t mask_wdata,
    input  logic       mask_we,
    output logic       any_err,
    output logic       held_err
);
    typedef struct packed {
        cause_vec_t mask;
    } gate_state_t;

    gate_state_t st_d, st_q;
    cause_vec_t  hit;

    for (genvar i = 0; i < NCAUSE; i++) begin : g_hit
        assign hit[i] = events[i] & st_q.mask[i];
    end

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= MASK_AT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign any_err  = |hit;
    assign held_err = |(hit & HELD_CAUSES);
endmodule

// File: rtl/rxf_release_timer.sv
module rxf_release_timer #(
    parameter int WAIT_SEL0 = 48,
    parameter int WAIT_SEL1 = 12,
    parameter int WAIT_SEL2 = 6,
    parameter int WAIT_SEL3 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_start,
    input  logic [1:0] rel_sel,
    input  logic       any_err,
    input  logic       held_err,
    output logic       hold
);
    localparam int MAX01 = (WAIT_SEL0 > WAIT_SEL1) ? WAIT_SEL0 : WAIT_SEL1;
    localparam int MAX23 = (WAIT_SEL2 > WAIT_SEL3) ? WAIT_SEL2 : WAIT_SEL3;
    localparam int MAXW  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXW + 1);

    typedef struct packed {
        logic             hold;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        case (rel_sel)
            2'b00:   target = CNT_W'(WAIT_SEL0);
            2'b01:   target = CNT_W'(WAIT_SEL1);
            2'b10:   target = CNT_W'(WAIT_SEL2);
            default: target = CNT_W'(WAIT_SEL3);
        endcase
    end

    assign cnt_inc = {1'b0, st_q.cnt} + 1'b1;

    always_comb begin
        st_d = st_q;
        if (held_err) begin
            st_d.hold = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hold) begin
            if (any_err) begin
                st_d.cnt = '0;
            end else if (blk_start) begin
                if (cnt_inc >= {1'b0, target}) begin
                    st_d.hold = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = st_q.hold;

    // R4 / R7: release happens only on a clean strobe cycle
    a_r4_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> ($past(blk_start) && !$past(any_err)));

    // R5: an error during the hold clears the count and keeps the hold
    a_r5_err_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && any_err) |=> (st_q.hold && st_q.cnt == '0));

    // R4: a held cause always starts a fresh hold
    a_r4_held_sets: assert property (@(posedge clk) disable iff (!rst_n)
        held_err |=> (st_q.hold && st_q.cnt == '0));
endmodule

// File: rtl/rxf_pin_mux.sv
module rxf_pin_mux
    import rxf_pkg::*;
(
    input  logic             err_flag,
    input  logic             gate_mode,
    input  logic [SRC_W-1:0] main_src,
    input  logic             pin_sel,
    input  logic             irq_in,
    input  logic             pin_hiz,
    output logic             pin_out,
    output logic             pin_oe
);
    logic src_is_rx;
    logic status;

    assign src_is_rx = (main_src == SRC_W'(SRC_AUTO)) || (main_src == SRC_W'(SRC_RX));

    always_comb begin
        if (gate_mode && !src_is_rx) begin
            status = 1'b1;
        end else begin
            status = err_flag;
        end
        pin_out = pin_sel ? irq_in : status;
        pin_oe  = ~pin_hiz;
    end
endmodule

// File: rtl/rx_fault_flag.sv
module rx_fault_flag
    import rxf_pkg::*;
#(
    parameter int WAIT_SEL0 = 48,
    parameter int WAIT_SEL1 = 12,
    parameter int WAIT_SEL2 = 6,
    parameter int WAIT_SEL3 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_unlock,
    input  logic             ev_parity,
    input  logic             ev_validity,
    input  logic             ev_nonpcm,
    input  logic             ev_rate_lim,
    input  logic             ev_rate_chg,
    input  logic             blk_start,
    input  logic [5:0]       mask_wdata,
    input  logic             mask_we,
    input  logic [1:0]       rel_sel,
    input  logic             gate_mode,
    input  logic [2:0]       main_src,
    input  logic             pin_sel,
    input  logic             irq_in,
    input  logic             pin_hiz,
    output logic             err_flag,
    output logic             pin_out,
    output logic             pin_oe
);
    cause_vec_t events;
    logic       any_err;
    logic       held_err;
    logic       hold;

    always_comb begin
        events             = '0;
        events[C_UNLOCK]   = ev_unlock;
        events[C_PARITY]   = ev_parity;
        events[C_VALIDITY] = ev_validity;
        events[C_NONPCM]   = ev_nonpcm;
        events[C_RATE_LIM] = ev_rate_lim;
        events[C_RATE_CHG] = ev_rate_chg;
    end

    rxf_cause_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .events     (events),
        .mask_wdata (mask_wdata),
        .mask_we    (mask_we),
        .any_err    (any_err),
        .held_err   (held_err)
    );

    rxf_release_timer #(
        .WAIT_SEL0 (WAIT_SEL0),
        .WAIT_SEL1 (WAIT_SEL1),
        .WAIT_SEL2 (WAIT_SEL2),
        .WAIT_SEL3 (WAIT_SEL3)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .rel_sel   (rel_sel),
        .any_err   (any_err),
        .held_err  (held_err),
        .hold      (hold)
    );

    assign err_flag = hold | any_err;

    rxf_pin_mux u_pin (
        .err_flag  (err_flag),
        .gate_mode (gate_mode),
        .main_src  (main_src),
        .pin_sel   (pin_sel),
        .irq_in    (irq_in),
        .pin_hiz   (pin_hiz),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // R8: non-receiver source under gating forces the error level on the pin
    a_r8_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode && !pin_sel && main_src > 3'd1) |-> pin_out);

    // R10: the driver is off whenever high impedance is requested
    a_r10_hiz_off: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz |-> !pin_oe);

    // R3: the flag never drops while the timer still holds
    a_r3_hold_shows: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> err_flag);
endmodule

// File: tb/rx_fault_flag_bench.sv
module rx_fault_flag_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_unlock = 0, ev_parity = 0, ev_validity = 0;
    logic       ev_nonpcm = 0, ev_rate_lim = 0, ev_rate_chg = 0;
    logic       blk_start = 0;
    logic [5:0] mask_wdata = '0;
    logic       mask_we = 0;
    logic [1:0] rel_sel = 2'b11;
    logic       gate_mode = 0;
    logic [2:0] main_src = 3'd0;
    logic       pin_sel = 0, irq_in = 0, pin_hiz = 0;
    logic       err_flag, pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rx_fault_flag u_rx_fault_flag (
        .clk(clk), .rst_n(rst_n),
        .ev_unlock(ev_unlock), .ev_parity(ev_parity), .ev_validity(ev_validity),
        .ev_nonpcm(ev_nonpcm), .ev_rate_lim(ev_rate_lim), .ev_rate_chg(ev_rate_chg),
        .blk_start(blk_start), .mask_wdata(mask_wdata), .mask_we(mask_we),
        .rel_sel(rel_sel), .gate_mode(gate_mode), .main_src(main_src),
        .pin_sel(pin_sel), .irq_in(irq_in), .pin_hiz(pin_hiz),
        .err_flag(err_flag), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive on falling edge, sample 1 ns later (well before next rising edge)
    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); blk_start = 1'b1;
            @(negedge clk); blk_start = 1'b0;
        end
        #1;
    endtask

    task automatic write_mask(input logic [5:0] m);
        @(negedge clk); mask_we = 1'b1; mask_wdata = m;
        @(negedge clk); mask_we = 1'b0;
        #1;
    endtask

    task automatic unlock_pulse();
        @(negedge clk); ev_unlock = 1'b1;
        @(negedge clk); ev_unlock = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 flag high in reset", err_flag, 1'b1);
        rst_n = 1'b1;
        settle();
        check("R3 flag high after reset", err_flag, 1'b1);
        check("R10 oe after reset", pin_oe, 1'b1);
        check("R8 pin follows flag", pin_out, 1'b1);
        rel_sel = 2'b11;
        strobe(2);
        check("R3 still held after 2 of 3", err_flag, 1'b1);
        strobe(1);
        check("R3 first release", err_flag, 1'b0);
        // default mask: parity disabled
        @(negedge clk); ev_parity = 1'b1; #1;
        check("R3 parity off by default", err_flag, 1'b0);
        @(negedge clk); ev_parity = 1'b0; ev_unlock = 1'b1; #1;
        check("R1 unlock same cycle", err_flag, 1'b1);
        @(negedge clk); ev_unlock = 1'b0;
        strobe(3);
        check("R4 release after 3", err_flag, 1'b0);
    endtask

    task automatic t_release(input logic [1:0] sel, input int n);
        rel_sel = sel;
        unlock_pulse();
        check("R4 held after event", err_flag, 1'b1);
        strobe(n - 1);
        check("R4 held one strobe short", err_flag, 1'b1);
        strobe(1);
        check("R4 released on final strobe", err_flag, 1'b0);
    endtask

    task automatic t_restart();
        rel_sel = 2'b11;
        unlock_pulse();
        strobe(2);
        unlock_pulse();
        strobe(2);
        check("R5 count restarted", err_flag, 1'b1);
        strobe(1);
        check("R5 release after restart", err_flag, 1'b0);
    endtask

    task automatic t_no_strobe();
        rel_sel = 2'b11;
        unlock_pulse();
        repeat (100) @(negedge clk);
        #1;
        check("R7 no strobe keeps hold", err_flag, 1'b1);
        strobe(3);
        check("R7 released by strobes", err_flag, 1'b0);
    endtask

    task automatic t_mask();
        write_mask(6'b000010);
        unlock_pulse();
        check("R2 masked unlock ignored", err_flag, 1'b0);
        @(negedge clk); ev_parity = 1'b1; #1;
        check("R6 parity raises flag", err_flag, 1'b1);
        @(negedge clk); ev_parity = 1'b0; #1;
        check("R6 parity not held", err_flag, 1'b0);
        write_mask(6'b111111);
        @(negedge clk); ev_validity = 1'b1; #1;
        check("R1 validity", err_flag, 1'b1);
        @(negedge clk); ev_validity = 1'b0; ev_nonpcm = 1'b1; #1;
        check("R1 nonpcm", err_flag, 1'b1);
        @(negedge clk); ev_nonpcm = 1'b0; #1;
        check("R6 nonpcm not held", err_flag, 1'b0);
        @(negedge clk); ev_rate_lim = 1'b1; #1;
        check("R1 rate limit", err_flag, 1'b1);
        @(negedge clk); ev_rate_lim = 1'b0; #1;
        check("R4 rate limit held", err_flag, 1'b1);
        rel_sel = 2'b11;
        strobe(3);
        check("R4 rate limit released", err_flag, 1'b0);
        @(negedge clk); ev_rate_chg = 1'b1; #1;
        check("R1 rate change", err_flag, 1'b1);
        @(negedge clk); ev_rate_chg = 1'b0; #1;
        check("R4 rate change held", err_flag, 1'b1);
        strobe(3);
        check("R4 rate change released", err_flag, 1'b0);
    endtask

    task automatic t_pin();
        @(negedge clk); gate_mode = 1'b1; main_src = 3'd2; #1;
        check("R8 forced high other source", pin_out, 1'b1);
        @(negedge clk); main_src = 3'd1; #1;
        check("R8 receiver shows flag", pin_out, err_flag);
        check("R8 receiver low when clean", pin_out, 1'b0);
        @(negedge clk); main_src = 3'd0; #1;
        check("R8 auto shows flag", pin_out, 1'b0);
        @(negedge clk); gate_mode = 1'b0; main_src = 3'd5; #1;
        check("R8 ungated shows flag", pin_out, 1'b0);
        @(negedge clk); pin_sel = 1'b1; irq_in = 1'b1; #1;
        check("R9 irq routed high", pin_out, 1'b1);
        @(negedge clk); irq_in = 1'b0; ev_parity = 1'b1; #1;
        check("R9 irq routed low", pin_out, 1'b0);
        @(negedge clk); ev_parity = 1'b0; pin_sel = 1'b0; pin_hiz = 1'b1; #1;
        check("R10 hiz turns driver off", pin_oe, 1'b0);
        @(negedge clk); pin_hiz = 1'b0; #1;
        check("R10 driver back on", pin_oe, 1'b1);
    endtask

    initial begin
        t_reset();
        t_release(2'b00, 48);
        t_release(2'b01, 12);
        t_release(2'b10, 6);
        t_release(2'b11, 3);
        t_restart();
        t_no_strobe();
        t_mask();
        t_pin();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule